// File: doc/BRIEF.md
# Programmable Counter Channel

A single down-counting timer channel. A host loads an initial count, a mode and a number base (binary or BCD) in one cycle. On every following clock-enable tick the channel either starts, steps or pauses. Each step lowers the counter by one, or by two in square-wave mode. Six modes give different waveforms on the output pin from the same counter: a terminal-count level, a one-shot window, a rate pulse, a square wave, and a single strobe triggered either by the load or by a gate edge. The live counter value is always visible for readback.

The gate input behaves in one of two ways, chosen by the mode. In the two level-gated modes it only pauses counting. In the other four modes a rising edge restarts the count from the initial value. A loaded count of zero stands for the largest count the chosen base can hold. Reset leaves the channel unprogrammed and idle until its first load.

Top module: `prog_timer_chan`

## Requirements
- R1: After reset, and until the first load, `count_o` reads 0 and `out_o` is low, whatever `tick_i` does.
- R2: A load pulse takes effect on the first tick after it: that tick sets `count_o` to the loaded count. Each further tick is one step, and the number of steps since that tick is the elapsed count d.
- R3: A loaded count of 0 means 65536 in binary or 10000 in BCD. In binary, one step of mode 0 gives 0xFFFF and one step of mode 3 gives 0xFFFE. In BCD, one step gives 0x9999.
- R4: Mode 0 (`mode_i`=0): `out_o` is low until d reaches the count N, then stays high. The counter goes on down through 0 and wraps to 0xFFFF.
- R5: Mode 1: `out_o` is high while d < N and low from then on. The counter keeps wrapping.
- R6: Mode 2: the counter reloads N each time it would reach 0. `out_o` is high for exactly one tick interval after each reload, which happens when d is a nonzero multiple of N.
- R7: Mode 3: the counter steps by two. `out_o` is high for ceil(N/2) ticks and low for floor(N/2) ticks of each N-tick period. The low half reloads N, or N-1 when N is odd.
- R8: Modes 4 and 5: `out_o` is high only for the tick interval where d equals N. It is low on the next tick, including after the wrap to 0xFFFF.
- R9: In modes 0 and 4 a low `gate_i` holds the counter on ticks, and a rising edge of `gate_i` does not restart it.
- R10: In modes 1, 2, 3 and 5 a rising edge of `gate_i`, seen on the clock, restarts the channel from N on the next tick and returns `out_o` to its starting level.
- R11: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R12: With `bcd_i`=1 each nibble counts in decimal and borrows from 0 to 9. For example 0x0100 steps to 0x0099, and 0x0000 steps to 0x9999.
- R13: Cycles without `tick_i` never change `count_o`, including the cycle of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one step per cycle high |
| gate_i | input | 1 | Gate level: pause or retrigger, by mode |
| load_i | input | 1 | One-cycle pulse taking mode, base and count |
| mode_i | input | 3 | Operating mode code, 6 and 7 alias 2 and 3 |
| bcd_i | input | 1 | 1 selects decimal counting |
| count_i | input | 16 | Initial count, 0 means maximum |
| count_o | output | 16 | Live counter value |
| out_o | output | 1 | Channel output level |

## Verification
The bench targets the terminal-count wrap to 0xFFFF and 0x9999 and the zero-means-maximum count. A design that stopped at zero, or treated zero as an empty count, would show 0 where 0xFFFF, 0xFFFE or 0x9999 is expected. It also uses odd square-wave counts, where a design with the wrong split would give a period of N+1 or an equal high and low time. Gate behaviour is checked in both directions: a level-gated mode that retriggers would jump back to N, and a retrigger mode that ignored the edge would keep counting down. BCD borrows across several nibbles are also checked, since a binary borrow would produce 0x00FF-style values.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } mode_e;

  function automatic mode_e map_mode(input logic [2:0] code);
    case (code)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return mode_e'(code);
    endcase
  endfunction

  function automatic logic is_gated(input mode_e m);
    return (m == M_TERM) || (m == M_SWSTROBE);
  endfunction

  function automatic logic is_strobe(input mode_e m);
    return (m == M_RATE) || (m == M_SWSTROBE) || (m == M_HWSTROBE);
  endfunction

  // output level right after a start or retrigger
  function automatic logic start_level(input mode_e m);
    return (m == M_ONESHOT) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/ptc_edge.sv
module ptc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/ptc_decr.sv
module ptc_decr #(
  parameter int CW   = 16,
  parameter int STEP = 1
) (
  input  logic [CW-1:0] val_i,
  input  logic          bcd_i,
  output logic [CW-1:0] res_o
);
  localparam int DIG = CW / 4;

  logic [CW-1:0] bin_res;
  logic [CW-1:0] bcd_res;
  logic [4:0]    dgt;
  int            brw;

  assign bin_res = val_i - CW'(STEP);

  always_comb begin
    brw     = STEP;
    bcd_res = '0;
    dgt     = '0;
    for (int i = 0; i < DIG; i++) begin
      dgt = {1'b0, val_i[4*i +: 4]};
      if (dgt >= 5'(brw)) begin
        bcd_res[4*i +: 4] = 4'(dgt - 5'(brw));
        brw = 0;
      end else begin
        bcd_res[4*i +: 4] = 4'(dgt + 5'd10 - 5'(brw));
        brw = 1;
      end
    end
  end

  assign res_o = bcd_i ? bcd_res : bin_res;
endmodule

// File: rtl/ptc_cfg.sv
module ptc_cfg
  import ptc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [2:0]    mode_i,
  input  logic          bcd_i,
  input  logic [CW-1:0] count_i,
  output logic          cfg_o,
  output mode_e         mode_o,
  output logic          bcd_o,
  output logic [CW:0]   init_o,
  output logic [CW:0]   lo_o
);
  logic [CW:0] init_d;

  // zero maps to the full range; bit CW means 2^CW or 10^(CW/4) alike
  assign init_d = {(count_i == '0), count_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= 1'b0;
      mode_o <= M_TERM;
      bcd_o  <= 1'b0;
      init_o <= '0;
      lo_o   <= '0;
    end else if (load_i) begin
      cfg_o  <= 1'b1;
      mode_o <= map_mode(mode_i);
      bcd_o  <= bcd_i;
      init_o <= init_d;
      // odd counts shorten the low half by one; bit 0 clear never borrows
      lo_o   <= {init_d[CW:1], 1'b0};
    end
  end
endmodule

// File: rtl/prog_timer_chan.sv
module prog_timer_chan
  import ptc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          load_i,
  input  logic [2:0]    mode_i,
  input  logic          bcd_i,
  input  logic [CW-1:0] count_i,
  output logic [CW-1:0] count_o,
  output logic          out_o
);
  localparam logic [CW:0] ONE = (CW+1)'(1);
  localparam logic [CW:0] TWO = (CW+1)'(2);

  logic        cfg_q, bcd_q;
  mode_e       mode_q;
  logic [CW:0] init_q, lo_q;
  logic [CW:0] cnt_q;
  logic        run_q, pend_q, trig_q, done_q, half_q, out_q;
  logic        rise_w, can_step, restart, trig_set;
  logic [CW-1:0] dec_w [2];
  logic [CW:0] stp_cnt;
  logic        stp_done, stp_half, stp_out;

  ptc_cfg #(.CW(CW)) cfg_u (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .mode_i (mode_i),
    .bcd_i  (bcd_i),
    .count_i(count_i),
    .cfg_o  (cfg_q),
    .mode_o (mode_q),
    .bcd_o  (bcd_q),
    .init_o (init_q),
    .lo_o   (lo_q)
  );

  ptc_edge gate_edge_u (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (gate_i),
    .rise_o(rise_w)
  );

  for (genvar s = 0; s < 2; s++) begin : g_dec
    ptc_decr #(.CW(CW), .STEP(s + 1)) dec_u (
      .val_i(cnt_q[CW-1:0]),
      .bcd_i(bcd_q),
      .res_o(dec_w[s])
    );
  end

  assign restart  = pend_q | trig_q;
  assign can_step = run_q & (~is_gated(mode_q) | gate_i);
  assign trig_set = rise_w & cfg_q & ~is_gated(mode_q) & (run_q | pend_q);

  always_comb begin
    stp_cnt  = {1'b0, dec_w[0]};
    stp_done = done_q;
    stp_half = half_q;
    stp_out  = 1'b0;
    case (mode_q)
      M_RATE: begin
        if (cnt_q == ONE) begin
          stp_cnt = init_q;
          stp_out = 1'b1;
        end
      end
      M_SQUARE: begin
        if (cnt_q <= TWO) begin
          if ((init_q == ONE) || half_q) begin
            stp_cnt  = init_q;
            stp_half = 1'b0;
          end else begin
            stp_cnt  = lo_q;
            stp_half = 1'b1;
          end
        end else begin
          stp_cnt = {1'b0, dec_w[1]};
        end
        stp_out = ~stp_half;
      end
      default: begin
        stp_done = done_q | (dec_w[0] == '0);
        case (mode_q)
          M_TERM:    stp_out = stp_done;
          M_ONESHOT: stp_out = ~stp_done;
          default:   stp_out = (dec_w[0] == '0) & ~done_q;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
      half_q <= 1'b0;
      out_q  <= 1'b0;
    end else if (load_i) begin
      pend_q <= 1'b1;
      run_q  <= 1'b0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
      half_q <= 1'b0;
      out_q  <= start_level(map_mode(mode_i));
    end else begin
      if (trig_set)               trig_q <= 1'b1;
      else if (tick_i && restart) trig_q <= 1'b0;
      if (tick_i) begin
        if (restart) begin
          cnt_q  <= init_q;
          run_q  <= 1'b1;
          pend_q <= 1'b0;
          done_q <= 1'b0;
          half_q <= 1'b0;
          out_q  <= start_level(mode_q);
        end else if (can_step) begin
          cnt_q  <= stp_cnt;
          done_q <= stp_done;
          half_q <= stp_half;
          out_q  <= stp_out;
        end else if (is_strobe(mode_q)) begin
          out_q  <= 1'b0;
        end
      end
    end
  end

  assign count_o = cnt_q[CW-1:0];
  assign out_o   = out_q;
endmodule

// File: rtl/ptc_chk.sv
module ptc_chk
  import ptc_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          load_i,
  input logic [CW-1:0] count_o,
  input logic          out_o,
  input logic          cfg_q,
  input mode_e         mode_q,
  input logic [CW:0]   init_q
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q |-> (count_o == '0) && !out_o);

  // R13
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

  // R4
  term_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q && mode_q == M_TERM && out_o && !load_i) |=> out_o);

  // R6
  rate_pulse_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q && mode_q == M_RATE && out_o) |-> count_o == init_q[CW-1:0]);

  // R8
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q && (mode_q == M_SWSTROBE || mode_q == M_HWSTROBE) && out_o
     && tick_i && !load_i) |=> !out_o);
endmodule

bind prog_timer_chan ptc_chk #(.CW(CW)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .load_i (load_i),
  .count_o(count_o),
  .out_o  (out_o),
  .cfg_q  (cfg_q),
  .mode_q (mode_q),
  .init_q (init_q)
);

// File: tb/prog_timer_chan_tb_top.sv
`timescale 1ns/1ps
module prog_timer_chan_tb_top;

  typedef struct packed {
    logic [2:0]  mode;
    logic        bcd;
    logic [15:0] cnt;
    logic [7:0]  d;
    logic [15:0] ecnt;
    logic        eout;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 16'h0005, 8'd4, 16'h0001, 1'b0, 4'd4},  // R4
    '{3'd0, 1'b0, 16'h0005, 8'd5, 16'h0000, 1'b1, 4'd4},  // R4
    '{3'd0, 1'b0, 16'h0005, 8'd6, 16'hFFFF, 1'b1, 4'd4},  // R4 wrap
    '{3'd1, 1'b0, 16'h0003, 8'd2, 16'h0001, 1'b1, 4'd5},  // R5
    '{3'd1, 1'b0, 16'h0003, 8'd3, 16'h0000, 1'b0, 4'd5},  // R5
    '{3'd2, 1'b0, 16'h0004, 8'd3, 16'h0001, 1'b0, 4'd6},  // R6
    '{3'd2, 1'b0, 16'h0004, 8'd4, 16'h0004, 1'b1, 4'd6},  // R6
    '{3'd2, 1'b0, 16'h0004, 8'd5, 16'h0003, 1'b0, 4'd6},  // R6
    '{3'd3, 1'b0, 16'h0006, 8'd2, 16'h0002, 1'b1, 4'd7},  // R7
    '{3'd3, 1'b0, 16'h0006, 8'd3, 16'h0006, 1'b0, 4'd7},  // R7
    '{3'd3, 1'b0, 16'h0006, 8'd6, 16'h0006, 1'b1, 4'd7},  // R7
    '{3'd3, 1'b0, 16'h0005, 8'd2, 16'h0001, 1'b1, 4'd7},  // R7 odd
    '{3'd3, 1'b0, 16'h0005, 8'd3, 16'h0004, 1'b0, 4'd7},  // R7 odd
    '{3'd3, 1'b0, 16'h0005, 8'd5, 16'h0005, 1'b1, 4'd7},  // R7 odd
    '{3'd4, 1'b0, 16'h0003, 8'd3, 16'h0000, 1'b1, 4'd8},  // R8
    '{3'd4, 1'b0, 16'h0003, 8'd4, 16'hFFFF, 1'b0, 4'd8},  // R8
    '{3'd5, 1'b0, 16'h0002, 8'd2, 16'h0000, 1'b1, 4'd8},  // R8
    '{3'd6, 1'b0, 16'h0002, 8'd2, 16'h0002, 1'b1, 4'd11}, // R11
    '{3'd7, 1'b0, 16'h0004, 8'd2, 16'h0004, 1'b0, 4'd11}, // R11
    '{3'd0, 1'b0, 16'h0000, 8'd1, 16'hFFFF, 1'b0, 4'd3},  // R3
    '{3'd0, 1'b1, 16'h0000, 8'd1, 16'h9999, 1'b0, 4'd3},  // R3
    '{3'd0, 1'b1, 16'h0100, 8'd1, 16'h0099, 1'b0, 4'd12}, // R12
    '{3'd0, 1'b1, 16'h1000, 8'd2, 16'h0998, 1'b0, 4'd12}, // R12
    '{3'd0, 1'b1, 16'h0001, 8'd2, 16'h9999, 1'b1, 4'd12}, // R12
    '{3'd3, 1'b1, 16'h0010, 8'd1, 16'h0008, 1'b1, 4'd12}, // R12
    '{3'd2, 1'b1, 16'h0012, 8'd3, 16'h0009, 1'b0, 4'd12}, // R12
    '{3'd3, 1'b0, 16'h0000, 8'd1, 16'hFFFE, 1'b1, 4'd3}   // R3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b1;
  logic        load_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        bcd_i = 1'b0;
  logic [15:0] count_i = '0;
  logic [15:0] count_o;
  logic        out_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  prog_timer_chan dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .gate_i (gate_i),
    .load_i (load_i),
    .mode_i (mode_i),
    .bcd_i  (bcd_i),
    .count_i(count_i),
    .count_o(count_o),
    .out_o  (out_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] m, input logic b, input logic [15:0] c);
    @(negedge clk_i);
    load_i = 1'b1; mode_i = m; bcd_i = b; count_i = c;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pulses;
    logic [15:0] prev;
    idle(4);
    rst_ni = 1'b1;
    idle(2);
    // R1 reset state and no counting before programming
    chk("R1 count", count_o, 16'h0);
    chk("R1 out", {15'b0, out_o}, 16'h0);
    ticks(3);
    chk("R1 count after ticks", count_o, 16'h0);
    chk("R1 out after ticks", {15'b0, out_o}, 16'h0);

    // vector table: load, start tick, then d steps
    for (int v = 0; v < NV; v++) begin
      load(VEC[v].mode, VEC[v].bcd, VEC[v].cnt);
      ticks(int'(VEC[v].d) + 1);
      chk($sformatf("R%0d count vec%0d", VEC[v].req, v), count_o, VEC[v].ecnt);
      chk($sformatf("R%0d out vec%0d", VEC[v].req, v), {15'b0, out_o}, {15'b0, VEC[v].eout});
    end

    // R13 load and idle cycles leave the counter alone; R2 first tick loads
    prev = count_o;
    load(3'd0, 1'b0, 16'd7);
    idle(4);
    chk("R13 count held", count_o, prev);
    ticks(1);
    chk("R2 start value", count_o, 16'd7);

    // R9 gate pauses mode 0 and its rising edge does not restart
    load(3'd0, 1'b0, 16'd5);
    ticks(1);
    @(negedge clk_i); gate_i = 1'b0;
    ticks(3);
    chk("R9 paused", count_o, 16'd5);
    @(negedge clk_i); gate_i = 1'b1;
    idle(2);
    ticks(1);
    chk("R9 no restart", count_o, 16'd4);

    // R10 gate edge retriggers mode 1 after expiry
    load(3'd1, 1'b0, 16'd4);
    ticks(3);
    chk("R5 window", {15'b0, out_o}, 16'h1);
    ticks(2);
    chk("R5 expired", {15'b0, out_o}, 16'h0);
    @(negedge clk_i); gate_i = 1'b0;
    idle(1);
    @(negedge clk_i); gate_i = 1'b1;
    idle(2);
    ticks(1);
    chk("R10 reload", count_o, 16'd4);
    chk("R10 out level", {15'b0, out_o}, 16'h1);
    ticks(1);
    chk("R10 counting", count_o, 16'd3);

    // R10 mode 5 retrigger after strobe
    load(3'd5, 1'b0, 16'd2);
    ticks(3);
    chk("R8 strobe", {15'b0, out_o}, 16'h1);
    @(negedge clk_i); gate_i = 1'b0;
    idle(1);
    @(negedge clk_i); gate_i = 1'b1;
    idle(2);
    ticks(1);
    chk("R10 mode5 reload", count_o, 16'd2);
    chk("R10 mode5 out", {15'b0, out_o}, 16'h0);

    // R6 three pulses over nine steps of N=3
    load(3'd2, 1'b0, 16'd3);
    ticks(1);
    pulses = 0;
    for (int k = 0; k < 9; k++) begin
      ticks(1);
      if (out_o) pulses++;
    end
    chk("R6 pulse count", 16'(pulses), 16'd3);

    // R7 N=7: 4 high of 7 per period, two periods
    load(3'd3, 1'b0, 16'd7);
    pulses = 0;
    for (int k = 0; k < 14; k++) begin
      ticks(1);
      if (out_o) pulses++;
    end
    chk("R7 high ticks", 16'(pulses), 16'd8);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule